// File: doc/BRIEF.md
# Boot-Time Sampling Clock Source Configurator

This block is a one-shot power-up sequencer for an external clock-distribution buffer. It runs from a free-running oscillator clock that never depends on the clock it is choosing. Once reset is released and the boot clock is reported stable, it reads a two-bit switch field and picks the off-board or on-board sampling clock input. It then sends a short, fixed list of single-byte register writes to the buffer over a write-only SPI link and stops for good.

While it works, the block holds a reset-style `clocks_invalid` output high. Logic that is clocked by the sampling clock can therefore stay in reset until the buffer has been told which input to use. If the boot-clock qualifier drops before the list is finished, the SPI transfer stops at once and `clocks_invalid` stays high. When the qualifier returns, the whole list is sent again from the first entry.

Top module: `clkboot_cfg`

## Requirements
- R1: While `rst_n` is low, at the clock edge the block holds `spi_cs_n` high, `spi_sclk` low and `clocks_invalid` high.
- R2: While `clk_ok` is low, `spi_cs_n` stays high one cycle later and no write is started.
- R3: The switch code `cfg_sw == 2'b00` selects the off-board input, which writes 0x1D to register 0x045. The codes 01, 10 and 11 select the on-board input, which writes 0x1A to the same register.
- R4: Each write is one 24-bit frame sent MSB first with `spi_cs_n` low for the whole frame. Bit 23 is 0 (write), bits 22:21 are 00 (one byte), bits 20:8 are the 13-bit register address and bits 7:0 are the data. `spi_mosi` is stable while `spi_sclk` is high, and the receiver samples it on the rising edge of `spi_sclk`. `spi_sclk` idles low.
- R5: The write list is sent in this fixed order: 0x040←0x02, 0x045←(input select, see R3), 0x04A←0x00, 0x05A←0x01. The final write to 0x05A makes the buffer apply the new settings.
- R6: Within a frame, `spi_sclk` has a period of `SCLK_DIV` boot-clock cycles and is high for `SCLK_DIV/2` of them.
- R7: Between two frames, `spi_cs_n` stays high for at least `GAP_SCLKS*SCLK_DIV` boot-clock cycles.
- R8: `clocks_invalid` is high at every rising edge of `spi_cs_n`, including the rising edge that ends the last frame. After the last frame it goes low and stays low, and no further frame is sent.
- R9: The switches pass through a two-flop synchronizer. They are sampled once, the first time `clk_ok` is seen high after reset. Later changes to the switches, including changes made while a restart is pending, have no effect.
- R10: If `clk_ok` drops before the list is finished, `spi_cs_n` is high on the next cycle and `clocks_invalid` stays high. When `clk_ok` returns, the list restarts from its first entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-running boot oscillator clock |
| rst_n | input | 1 | Synchronous active-low start-of-life reset |
| clk_ok | input | 1 | Boot clock qualifier (e.g. generator lock), synchronous to `clk` |
| cfg_sw | input | 2 | Clock-source switches, asynchronous |
| spi_cs_n | output | 1 | Active-low SPI chip select |
| spi_sclk | output | 1 | SPI serial clock, mode 0 |
| spi_mosi | output | 1 | SPI serial data to the buffer |
| clocks_invalid | output | 1 | High until the whole write list has completed |

## Verification
The bench builds the block with `SCLK_DIV = 4` and `GAP_SCLKS = 2`, which keeps a full four-write boot short. It runs all four switch codes through complete boots and decodes every frame against an arithmetic model. It also measures each serial clock period and high time exactly, and the chip-select gap between frames. Short runs leave room for further scenarios: a switch change after sampling, and a qualifier drop in the middle of a frame, where the bench counts the partial frame and then checks the full list restart.

// File: rtl/clkboot_pkg.sv
// Package for the boot-time clock source configurator.
// Holds the frame geometry, the state types and the write list.
// Assumes a single-byte write frame: {write=0, count=00, addr[12:0], data[7:0]}.
package clkboot_pkg;

    localparam int FRAME_W  = 24;
    localparam int ADDR_W   = 13;
    localparam int DATA_W   = 8;
    localparam int N_WRITES = 4;

    localparam logic [DATA_W-1:0] SEL_OFFBOARD = 8'h1D;
    localparam logic [DATA_W-1:0] SEL_ONBOARD  = 8'h1A;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_entry_t;

    typedef enum logic [1:0] {TX_IDLE, TX_BIT, TX_GAP} tx_state_t;
    typedef enum logic [1:0] {SQ_WAIT, SQ_SEND, SQ_DONE} sq_state_t;

    // Returns the write-list entry at position idx for the chosen mode.
    function automatic wr_entry_t write_entry(input int idx, input logic offboard);
        wr_entry_t e;
        case (idx)
            0:       begin e.addr = 13'h040; e.data = 8'h02; end
            1:       begin e.addr = 13'h045; e.data = offboard ? SEL_OFFBOARD : SEL_ONBOARD; end
            2:       begin e.addr = 13'h04A; e.data = 8'h00; end
            default: begin e.addr = 13'h05A; e.data = 8'h01; end
        endcase
        return e;
    endfunction

    // Wraps an entry into a single-byte write frame.
    function automatic logic [FRAME_W-1:0] build_frame(input wr_entry_t e);
        return {1'b0, 2'b00, e.addr, e.data};
    endfunction

endpackage

// File: rtl/clkboot_swcap.sv
// Switch synchronizer and one-time mode capture.
// The asynchronous switches pass through two flops. Once the pipeline holds
// real samples and the arm input is high, the mode is latched and then frozen
// until reset. Assumes arm is synchronous to clk.
module clkboot_swcap #(
    parameter int SW_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [SW_W-1:0] sw_in,
    input  logic            arm,
    output logic            mode_ready,
    output logic            mode_offboard
);

    logic [SW_W-1:0] sync_a;
    logic [SW_W-1:0] sync_b;
    logic [1:0]      fill;

    // Two-flop synchronizer plus a fill marker for valid samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_a <= '0;
            sync_b <= '0;
            fill   <= '0;
        end else begin
            sync_a <= sw_in;
            sync_b <= sync_a;
            fill   <= {fill[0], 1'b1};
        end
    end

    // Latches the mode once, at the first armed cycle with valid samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_ready    <= 1'b0;
            mode_offboard <= 1'b0;
        end else if (arm && fill[1] && !mode_ready) begin
            mode_ready    <= 1'b1;
            mode_offboard <= (sync_b == '0);
        end
    end

    p_mode_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mode_ready |=> (mode_ready && $stable(mode_offboard)));

endmodule

// File: rtl/clkboot_spi_tx.sv
// Write-only SPI mode-0 frame transmitter.
// Sends one FRAME_W-bit frame MSB first after a start pulse, then holds chip
// select high for a guard gap before pulsing done. Abort returns it to idle at
// once, with chip select high. Assumes DIV is even and at least 2.
module clkboot_spi_tx
    import clkboot_pkg::*;
#(
    parameter int DIV       = 8,
    parameter int GAP_SCLKS = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               abort,
    input  logic               start,
    input  logic [FRAME_W-1:0] frame,
    output logic               cs_n,
    output logic               sclk,
    output logic               mosi,
    output logic               done
);

    localparam int HALF    = DIV / 2;
    localparam int CW      = (DIV > 2) ? $clog2(DIV) : 1;
    localparam int GAP_CYC = GAP_SCLKS * DIV;
    localparam int GW      = $clog2(GAP_CYC + 1);
    localparam int BW      = $clog2(FRAME_W);

    tx_state_t          st;
    logic [FRAME_W-1:0] sh;
    logic [CW-1:0]      div_cnt;
    logic [BW-1:0]      bit_cnt;
    logic [GW-1:0]      gap_cnt;

    // Frame shifter, serial clock divider and inter-frame gap timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= TX_IDLE;
            cs_n    <= 1'b1;
            sclk    <= 1'b0;
            sh      <= '0;
            div_cnt <= '0;
            bit_cnt <= '0;
            gap_cnt <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (abort) begin
                st   <= TX_IDLE;
                cs_n <= 1'b1;
                sclk <= 1'b0;
            end else begin
                case (st)
                    TX_IDLE: begin
                        if (start) begin
                            sh      <= frame;
                            cs_n    <= 1'b0;
                            div_cnt <= '0;
                            bit_cnt <= '0;
                            st      <= TX_BIT;
                        end
                    end
                    TX_BIT: begin
                        if (div_cnt == CW'(HALF - 1)) sclk <= 1'b1;
                        if (div_cnt == CW'(DIV - 1)) begin
                            sclk    <= 1'b0;
                            div_cnt <= '0;
                            if (bit_cnt == BW'(FRAME_W - 1)) begin
                                cs_n    <= 1'b1;
                                gap_cnt <= '0;
                                st      <= TX_GAP;
                            end else begin
                                sh      <= {sh[FRAME_W-2:0], 1'b0};
                                bit_cnt <= bit_cnt + 1'b1;
                            end
                        end else begin
                            div_cnt <= div_cnt + 1'b1;
                        end
                    end
                    TX_GAP: begin
                        if (gap_cnt == GW'(GAP_CYC - 1)) begin
                            done <= 1'b1;
                            st   <= TX_IDLE;
                        end else begin
                            gap_cnt <= gap_cnt + 1'b1;
                        end
                    end
                    default: st <= TX_IDLE;
                endcase
            end
        end
    end

    // The data line always presents the current frame MSB.
    assign mosi = sh[FRAME_W-1];

    p_sclk_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);
    p_mosi_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));
    p_abort_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (cs_n && !sclk));

endmodule

// File: rtl/clkboot_seq.sv
// Boot write-list sequencer.
// Waits for a qualified boot clock and a captured mode, then requests one
// frame per list entry, in order. A qualifier drop sends it back to waiting,
// and the list restarts from entry zero. After the last frame it parks for good.
module clkboot_seq
    import clkboot_pkg::*;
#(
    parameter int NW = N_WRITES
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clk_ok,
    input  logic                mode_ready,
    input  logic                tx_done,
    output logic                start,
    output logic [$clog2(NW)-1:0] idx,
    output logic                invalid
);

    localparam int IW = $clog2(NW);

    sq_state_t st;

    // Walks the write list and issues one start pulse per entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= SQ_WAIT;
            idx   <= '0;
            start <= 1'b0;
        end else begin
            start <= 1'b0;
            case (st)
                SQ_WAIT: begin
                    if (clk_ok && mode_ready) begin
                        idx   <= '0;
                        start <= 1'b1;
                        st    <= SQ_SEND;
                    end
                end
                SQ_SEND: begin
                    if (!clk_ok) begin
                        st <= SQ_WAIT;
                    end else if (tx_done) begin
                        if (idx == IW'(NW - 1)) begin
                            st <= SQ_DONE;
                        end else begin
                            idx   <= idx + 1'b1;
                            start <= 1'b1;
                        end
                    end
                end
                default: st <= SQ_DONE;
            endcase
        end
    end

    // Downstream reset stays asserted until the list is complete.
    assign invalid = (st != SQ_DONE);

    p_done_final_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SQ_DONE) |=> (st == SQ_DONE && !start));
    p_start_qualified_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> $past(clk_ok));

endmodule

// File: rtl/clkboot_cfg.sv
// Top of the boot-time clock source configurator.
// Runs on the always-running oscillator clock. It captures the clock-source
// switches, pushes the write list to the clock buffer over SPI and holds
// clocks_invalid high until the last write has ended. Assumes clk_ok is
// synchronous to clk and that rst_n is released once after power-up.
module clkboot_cfg
    import clkboot_pkg::*;
#(
    parameter int SCLK_DIV  = 8,
    parameter int GAP_SCLKS = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clk_ok,
    input  logic [1:0] cfg_sw,
    output logic       spi_cs_n,
    output logic       spi_sclk,
    output logic       spi_mosi,
    output logic       clocks_invalid
);

    localparam int IW = $clog2(N_WRITES);

    logic               mode_ready;
    logic               mode_offboard;
    logic               tx_start;
    logic               tx_done;
    logic [IW-1:0]      wr_idx;
    logic [FRAME_W-1:0] cur_frame;

    clkboot_swcap #(.SW_W(2)) u_swcap (
        .clk           (clk),
        .rst_n         (rst_n),
        .sw_in         (cfg_sw),
        .arm           (clk_ok),
        .mode_ready    (mode_ready),
        .mode_offboard (mode_offboard)
    );

    clkboot_seq #(.NW(N_WRITES)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_ok     (clk_ok),
        .mode_ready (mode_ready),
        .tx_done    (tx_done),
        .start      (tx_start),
        .idx        (wr_idx),
        .invalid    (clocks_invalid)
    );

    // Frame for the current list position and the captured mode.
    always_comb cur_frame = build_frame(write_entry(int'(wr_idx), mode_offboard));

    clkboot_spi_tx #(.DIV(SCLK_DIV), .GAP_SCLKS(GAP_SCLKS)) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .abort (!clk_ok),
        .start (tx_start),
        .frame (cur_frame),
        .cs_n  (spi_cs_n),
        .sclk  (spi_sclk),
        .mosi  (spi_mosi),
        .done  (tx_done)
    );

    p_quiet_unqualified_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_ok |=> spi_cs_n);
    p_invalid_over_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_cs_n |-> clocks_invalid);
    p_invalid_never_returns_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !clocks_invalid |=> !clocks_invalid);

endmodule

// File: tb/clkboot_cfg_test.sv
module clkboot_cfg_test;

    localparam int DIV   = 4;
    localparam int GAPS  = 2;
    localparam int MAXF  = 128;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clk_ok = 1'b0;
    logic [1:0] cfg_sw = 2'b00;
    logic       spi_cs_n, spi_sclk, spi_mosi, clocks_invalid;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    clkboot_cfg #(.SCLK_DIV(DIV), .GAP_SCLKS(GAPS)) uut (
        .clk(clk), .rst_n(rst_n), .clk_ok(clk_ok), .cfg_sw(cfg_sw),
        .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .clocks_invalid(clocks_invalid)
    );

    // ---------------- SPI monitor, sampled at falling clock edge ----------------
    logic [23:0] fr_val [MAXF];
    bit          fr_inv [MAXF];
    bit          fr_ok  [MAXF];
    int          fr_gap [MAXF];
    int  nframes = 0;
    int  partials = 0;
    int  cs_low_cycles = 0;
    bit  prev_sclk = 1'b0;
    bit  prev_cs = 1'b1;
    int  bits = 0;
    logic [23:0] shreg = '0;
    int  since_rise = 0;
    int  hi_cnt = 0;
    int  cs_high_cnt = 0;
    int  gap_rec = 0;
    bit  per_ok = 1'b1;

    always @(negedge clk) begin
        since_rise++;
        if (!spi_cs_n && prev_cs) begin
            gap_rec = cs_high_cnt;
            bits = 0; per_ok = 1'b1; shreg = '0; hi_cnt = 0;
        end
        if (spi_sclk && !prev_sclk) begin
            if (bits > 0 && since_rise != DIV) per_ok = 1'b0;
            since_rise = 0;
            shreg = {shreg[22:0], spi_mosi};
            bits++;
        end
        if (!spi_sclk && prev_sclk) begin
            if (hi_cnt != DIV/2) per_ok = 1'b0;
            hi_cnt = 0;
        end
        if (spi_sclk) hi_cnt++;
        if (spi_cs_n && !prev_cs) begin
            if (bits == 24 && nframes < MAXF) begin
                fr_val[nframes] = shreg;
                fr_inv[nframes] = clocks_invalid;
                fr_ok[nframes]  = per_ok;
                fr_gap[nframes] = gap_rec;
                nframes++;
            end else begin
                partials++;
            end
        end
        if (spi_cs_n) cs_high_cnt++; else begin cs_high_cnt = 0; cs_low_cycles++; end
        prev_sclk = spi_sclk;
        prev_cs = spi_cs_n;
    end

    // ---------------- helpers ----------------
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] exp_frame(input int k, input bit off);
        logic [12:0] a;
        logic [7:0]  d;
        case (k)
            0: begin a = 13'h040; d = 8'h02; end
            1: begin a = 13'h045; d = off ? 8'h1D : 8'h1A; end
            2: begin a = 13'h04A; d = 8'h00; end
            default: begin a = 13'h05A; d = 8'h01; end
        endcase
        return {1'b0, 2'b00, a, d};
    endfunction

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset(input logic [1:0] sw);
        @(negedge clk);
        rst_n = 1'b0; clk_ok = 1'b0; cfg_sw = sw;
        cycles(3);
        chk("R1 cs_n in reset", spi_cs_n, 1'b1);
        chk("R1 sclk in reset", spi_sclk, 1'b0);
        chk("R1 invalid in reset", clocks_invalid, 1'b1);
        rst_n = 1'b1;
    endtask

    task automatic wait_valid_done();
        for (int i = 0; i < 5000; i++) begin
            if (!clocks_invalid) break;
            @(negedge clk);
        end
    endtask

    // Checks a complete list of four frames starting at base.
    task automatic check_list(input int base, input bit off);
        chk("R8 invalid released", clocks_invalid, 1'b0);
        chk("R5 frame count", nframes - base, 4);
        for (int k = 0; k < 4; k++) begin
            if (base + k < MAXF) begin
                if (k == 1) chk("R3 select write", fr_val[base+k], exp_frame(k, off));
                else        chk("R5 R4 list frame", fr_val[base+k], exp_frame(k, off));
                chk("R6 sclk timing", fr_ok[base+k], 1'b1);
                chk("R8 invalid at cs rise", fr_inv[base+k], 1'b1);
                if (k > 0) chk("R7 cs gap", fr_gap[base+k] >= GAPS*DIV, 1'b1);
            end
        end
    endtask

    // ---------------- main sequence ----------------
    initial begin
        int base;
        int lowc;
        int parts;
        // Full boots for every switch code.
        for (int s = 0; s < 4; s++) begin
            do_reset(s[1:0]);
            lowc = cs_low_cycles;
            cycles(40);
            chk("R2 no frame while clk_ok low", cs_low_cycles - lowc, 0);
            chk("R2 invalid while clk_ok low", clocks_invalid, 1'b1);
            base = nframes;
            clk_ok = 1'b1;
            wait_valid_done();
            check_list(base, s == 0);
            cycles(300);
            chk("R8 no later frames", nframes - base, 4);
            chk("R8 invalid stays low", clocks_invalid, 1'b0);
        end

        // R9: switch change after sampling has no effect.
        do_reset(2'b00);
        cycles(5);
        base = nframes;
        clk_ok = 1'b1;
        cycles(20);
        cfg_sw = 2'b11;
        wait_valid_done();
        check_list(base, 1'b1);

        // R10: qualifier drop mid-frame, then restart from first entry.
        do_reset(2'b01);
        cycles(5);
        base = nframes;
        clk_ok = 1'b1;
        for (int i = 0; i < 5000; i++) begin
            if (nframes - base >= 2 && !spi_cs_n) break;
            @(negedge clk);
        end
        cycles(10);
        parts = partials;
        chk("R10 mid-frame before drop", spi_cs_n, 1'b0);
        clk_ok = 1'b0;
        cfg_sw = 2'b00;
        @(negedge clk);
        chk("R10 cs_n after drop", spi_cs_n, 1'b1);
        chk("R10 invalid after drop", clocks_invalid, 1'b1);
        cycles(30);
        chk("R10 partial frame seen", partials - parts, 1);
        chk("R10 invalid held", clocks_invalid, 1'b1);
        base = nframes;
        clk_ok = 1'b1;
        wait_valid_done();
        check_list(base, 1'b0);   // R9: mode captured before the drop is kept

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule